// File: doc/BRIEF.md
# Descriptor-Chained Plane Parameter Loader

This block is the control engine of one graphics overlay plane. The plane's settings do not come from host registers. At each field sync the block reads a 16-word descriptor from memory, starting at the address held in its link pointer. It places the words in shadow registers, commits them together, and takes the descriptor's own link word as the next pointer. Two descriptors that point at each other form a loop. The plane therefore keeps alternating between a top-field node and a bottom-field node with no host action. The host changes the loop in one of two ways: it patches a link word in memory, or it writes the pointer register.

The block drives the active plane parameters and a plane-visible flag towards the pixel path. It also exposes a small register window, through which the host reads the live settings and status and writes the pointer.

The memory read port is a stream:
- A request (`mem_req_valid`, `mem_req_addr`) stays asserted and unchanged until `mem_req_ready` is high at a clock edge.
- Responses carry no ready signal. The block accepts one `mem_rsp_valid` beat in any cycle.
- Memory must return exactly one beat per accepted request, in request order.

Top module: `plane_node_fetcher`

## Requirements
- R1: After reset, `plane_visible` and `mem_req_valid` are low, and the pointer (byte offset 0x24) and status (byte offset 0x68) both read zero.
- R2: A `field_sync` sampled while idle, with a valid pointer P, issues exactly 16 word reads at byte addresses P, P+4, ... P+60, in that order. Each request is held stable while `mem_req_ready` is low.
- R3: When the 16th word returns, all plane settings change in a single cycle. The pointer is reloaded from descriptor word 9, the link word.
- R4: Bit 31 of descriptor word 0 (control) is the defer bit:
  - If it is set, the newly fetched settings stay hidden until the next `field_sync`, and become visible in the cycle after that sync edge.
  - If it is clear, they become visible right after the last word returns.
- R5: `plane_visible` is high only while a configuration is active and bits 1:0 of descriptor word 13 (properties) are both zero.
- R6: The size word, descriptor word 7, holds height in bits 31:16 and width in bits 15:0. Both parts are clamped, to a width of at most 3840 and a height of at most 2160.
- R7: A `field_sync` sampled while idle with a zero pointer makes no read and drives `plane_visible` low from the next cycle.
- R8: A `field_sync` sampled while idle with any of pointer bits 3:0 set makes no read and sets the sticky error bit, status bit 1. Writing 1 to status bit 1 clears it.
- R9: A `field_sync` that arrives while a fetch is running is ignored: no extra reads, no restart.
- R10: The host writes the pointer at byte offset 0x24. The write is used at the next `field_sync`, and it overrides the link word of any fetch in progress, including a write in the same cycle as the last returned word.
- R11: Descriptor word k reads back at byte offset 4k. Host writes to any offset other than the pointer and status offsets have no effect.
- R12: A pulse on `pix_underflow` sets the sticky status bit 0, which holds until 1 is written to it. Status bit 2 reads 1 while a fetch is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| field_sync | input | 1 | One-cycle field start pulse |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_data | input | 32 | Read data beat |
| reg_wr | input | 1 | Host register write strobe |
| reg_addr | input | REG_AW | Host register byte offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for reg_addr (combinational) |
| pix_underflow | input | 1 | Underflow pulse from the pixel path |
| plane_visible | output | 1 | Plane is shown on the mixer |
| plane_ctl | output | 32 | Active control word (format in bits 4:0) |
| plane_origin | output | 32 | Active viewport start, line 31:16, pixel 15:0 |
| plane_stop | output | 32 | Active viewport end, line 31:16, pixel 15:0 |
| plane_pix_addr | output | 32 | Active pixel memory address |
| plane_pitch | output | 32 | Active line pitch in bytes |
| plane_size | output | 32 | Active clamped source size |

## Verification
Two events can fall in the same clock edge:
- the commit of a finished descriptor, which reloads the pointer from the link word;
- a host write to the pointer.

The bench counts returned beats. It raises the pointer write on exactly the cycle that carries the 16th beat, then reads the pointer back and expects the host value, not the link word. A second overlap is the sync that promotes deferred settings while it also starts the next fetch. That case is judged by sampling the outputs one cycle after the sync edge, while the scoreboard checks the request addresses of the new fetch.

// File: rtl/plane_fetch_pkg.sv
package plane_fetch_pkg;
  localparam int WORD_W     = 32;
  localparam int NODE_WORDS = 16;
  localparam int IDX_W      = $clog2(NODE_WORDS);

  // descriptor word positions (register byte offset = 4 * position)
  localparam logic [IDX_W-1:0] W_CTL   = IDX_W'(0);
  localparam logic [IDX_W-1:0] W_ALPHA = IDX_W'(1);
  localparam logic [IDX_W-1:0] W_ORG   = IDX_W'(3);
  localparam logic [IDX_W-1:0] W_END   = IDX_W'(4);
  localparam logic [IDX_W-1:0] W_PIX   = IDX_W'(5);
  localparam logic [IDX_W-1:0] W_PITCH = IDX_W'(6);
  localparam logic [IDX_W-1:0] W_SIZE  = IDX_W'(7);
  localparam logic [IDX_W-1:0] W_LINK  = IDX_W'(9);
  localparam logic [IDX_W-1:0] W_KEYLO = IDX_W'(10);
  localparam logic [IDX_W-1:0] W_KEYHI = IDX_W'(11);
  localparam logic [IDX_W-1:0] W_PROP  = IDX_W'(13);
  localparam logic [IDX_W-1:0] W_LUT   = IDX_W'(15);

  localparam int STATUS_WORD = 26;  // byte offset 0x68
  localparam int ST_UNDERRUN = 0;
  localparam int ST_BADPTR   = 1;
  localparam int ST_BUSY     = 2;
  localparam int DEFER_BIT   = 31;
  localparam int ALIGN_BITS  = 4;
  localparam int HIDE_BITS   = 2;

  typedef struct packed {
    logic [WORD_W-1:0] ctl;
    logic [WORD_W-1:0] alpha;
    logic [WORD_W-1:0] org;
    logic [WORD_W-1:0] stop;
    logic [WORD_W-1:0] pix;
    logic [WORD_W-1:0] pitch;
    logic [WORD_W-1:0] size;
    logic [WORD_W-1:0] link;
    logic [WORD_W-1:0] key_lo;
    logic [WORD_W-1:0] key_hi;
    logic [WORD_W-1:0] prop;
    logic [WORD_W-1:0] lut;
  } node_cfg_t;

  typedef enum logic [0:0] {FS_IDLE, FS_RUN} fetch_state_e;
endpackage

// File: rtl/pf_fetch_seq.sv
module pf_fetch_seq
  import plane_fetch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_base,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              word_take,
  output logic [IDX_W-1:0]  word_idx,
  output logic              word_last,
  output logic              busy
);
  localparam int CNT_W   = IDX_W + 1;
  localparam int BYTE_SH = 2;

  fetch_state_e      state_q;
  logic [CNT_W-1:0]  sent_q;
  logic [IDX_W-1:0]  got_q;
  logic [ADDR_W-1:0] base_q;
  logic              all_sent;

  assign busy      = (state_q == FS_RUN);
  assign all_sent  = (sent_q == CNT_W'(NODE_WORDS));
  assign req_valid = busy && !all_sent;
  assign req_addr  = base_q + (ADDR_W'(sent_q[IDX_W-1:0]) << BYTE_SH);
  assign word_take = busy && rsp_valid;
  assign word_idx  = got_q;
  assign word_last = word_take && (got_q == IDX_W'(NODE_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      sent_q  <= '0;
      got_q   <= '0;
      base_q  <= '0;
    end else if (start && !busy) begin
      state_q <= FS_RUN;
      sent_q  <= '0;
      got_q   <= '0;
      base_q  <= start_base;
    end else if (busy) begin
      if (req_valid && req_ready) sent_q <= sent_q + CNT_W'(1);
      if (word_take)              got_q  <= got_q + IDX_W'(1);
      if (word_last)              state_q <= FS_IDLE;
    end
  end
endmodule

// File: rtl/pf_node_stage.sv
module pf_node_stage
  import plane_fetch_pkg::*;
#(
  parameter int MAX_W = 3840,
  parameter int MAX_H = 2160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_take,
  input  logic [IDX_W-1:0]  word_idx,
  input  logic [WORD_W-1:0] word_data,
  output node_cfg_t         cfg_nx
);
  localparam int HALF = WORD_W / 2;
  localparam logic [HALF-1:0] LIM_W = HALF'(MAX_W);
  localparam logic [HALF-1:0] LIM_H = HALF'(MAX_H);

  node_cfg_t cfg_q;

  function automatic logic [WORD_W-1:0] clamp_size(input logic [WORD_W-1:0] raw);
    logic [HALF-1:0] w;
    logic [HALF-1:0] h;
    w = (raw[HALF-1:0] > LIM_W) ? LIM_W : raw[HALF-1:0];
    h = (raw[WORD_W-1:HALF] > LIM_H) ? LIM_H : raw[WORD_W-1:HALF];
    return {h, w};
  endfunction

  // staged words with the beat of this cycle laid over them
  always_comb begin
    cfg_nx = cfg_q;
    if (word_take) begin
      case (word_idx)
        W_CTL:   cfg_nx.ctl    = word_data;
        W_ALPHA: cfg_nx.alpha  = word_data;
        W_ORG:   cfg_nx.org    = word_data;
        W_END:   cfg_nx.stop   = word_data;
        W_PIX:   cfg_nx.pix    = word_data;
        W_PITCH: cfg_nx.pitch  = word_data;
        W_SIZE:  cfg_nx.size   = clamp_size(word_data);
        W_LINK:  cfg_nx.link   = word_data;
        W_KEYLO: cfg_nx.key_lo = word_data;
        W_KEYHI: cfg_nx.key_hi = word_data;
        W_PROP:  cfg_nx.prop   = word_data;
        W_LUT:   cfg_nx.lut    = word_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         cfg_q <= '0;
    else if (word_take) cfg_q <= cfg_nx;
  end
endmodule

// File: rtl/pf_plane_regs.sv
module pf_plane_regs
  import plane_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_sync,
  input  logic              fetch_busy,
  input  logic              fetch_last,
  input  node_cfg_t         cfg_nx,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic              pix_underflow,
  output logic              start,
  output logic [ADDR_W-1:0] start_base,
  output node_cfg_t         act_cfg,
  output logic              plane_visible,
  output logic [WORD_W-1:0] ptr,
  output logic [WORD_W-1:0] reg_rdata
);
  localparam int SEL_W = REG_AW - 2;

  logic [SEL_W-1:0]  sel;
  logic              ptr_zero;
  logic              ptr_bad;
  logic              sync_go;
  logic              host_ptr_wr;
  logic              status_wr;
  logic [WORD_W-1:0] ptr_q;
  logic              host_owns_q;
  node_cfg_t         act_q;
  node_cfg_t         pend_q;
  logic              act_en_q;
  logic              pend_v_q;
  logic              uf_q;
  logic              err_q;

  assign sel         = reg_addr[REG_AW-1:2];
  assign ptr_zero    = (ptr_q == '0);
  assign ptr_bad     = |ptr_q[ALIGN_BITS-1:0];
  assign sync_go     = field_sync && !fetch_busy;
  assign start       = sync_go && !ptr_zero && !ptr_bad;
  assign start_base  = ptr_q[ADDR_W-1:0];
  assign host_ptr_wr = reg_wr && (sel == SEL_W'(W_LINK));
  assign status_wr   = reg_wr && (sel == SEL_W'(STATUS_WORD));

  // pointer: host write beats the link word of a fetch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q       <= '0;
      host_owns_q <= 1'b0;
    end else begin
      if (host_ptr_wr)                     ptr_q <= reg_wdata;
      else if (fetch_last && !host_owns_q) ptr_q <= cfg_nx.link;
      if (fetch_last)                      host_owns_q <= 1'b0;
      else if (host_ptr_wr && fetch_busy)  host_owns_q <= 1'b1;
    end
  end

  // active and deferred settings
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= '0;
      pend_q   <= '0;
      act_en_q <= 1'b0;
      pend_v_q <= 1'b0;
    end else if (sync_go) begin
      if (ptr_zero) begin
        act_en_q <= 1'b0;
        pend_v_q <= 1'b0;
      end else if (pend_v_q) begin
        act_q    <= pend_q;
        act_en_q <= 1'b1;
        pend_v_q <= 1'b0;
      end
    end else if (fetch_last) begin
      if (cfg_nx.ctl[DEFER_BIT]) begin
        pend_q   <= cfg_nx;
        pend_v_q <= 1'b1;
      end else begin
        act_q    <= cfg_nx;
        act_en_q <= 1'b1;
      end
    end
  end

  // sticky status bits, set wins over write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uf_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (pix_underflow)                          uf_q <= 1'b1;
      else if (status_wr && reg_wdata[ST_UNDERRUN]) uf_q <= 1'b0;
      if (sync_go && !ptr_zero && ptr_bad)        err_q <= 1'b1;
      else if (status_wr && reg_wdata[ST_BADPTR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_W'(W_CTL):   reg_rdata = act_q.ctl;
      SEL_W'(W_ALPHA): reg_rdata = act_q.alpha;
      SEL_W'(W_ORG):   reg_rdata = act_q.org;
      SEL_W'(W_END):   reg_rdata = act_q.stop;
      SEL_W'(W_PIX):   reg_rdata = act_q.pix;
      SEL_W'(W_PITCH): reg_rdata = act_q.pitch;
      SEL_W'(W_SIZE):  reg_rdata = act_q.size;
      SEL_W'(W_LINK):  reg_rdata = ptr_q;
      SEL_W'(W_KEYLO): reg_rdata = act_q.key_lo;
      SEL_W'(W_KEYHI): reg_rdata = act_q.key_hi;
      SEL_W'(W_PROP):  reg_rdata = act_q.prop;
      SEL_W'(W_LUT):   reg_rdata = act_q.lut;
      SEL_W'(STATUS_WORD): begin
        reg_rdata[ST_UNDERRUN] = uf_q;
        reg_rdata[ST_BADPTR]   = err_q;
        reg_rdata[ST_BUSY]     = fetch_busy;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign act_cfg       = act_q;
  assign plane_visible = act_en_q && (act_q.prop[HIDE_BITS-1:0] == '0);
  assign ptr           = ptr_q;
endmodule

// File: rtl/plane_node_fetcher.sv
module plane_node_fetcher
  import plane_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8,
  parameter int MAX_W  = 3840,
  parameter int MAX_H  = 2160
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_sync,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pix_underflow,
  output logic              plane_visible,
  output logic [31:0]       plane_ctl,
  output logic [31:0]       plane_origin,
  output logic [31:0]       plane_stop,
  output logic [31:0]       plane_pix_addr,
  output logic [31:0]       plane_pitch,
  output logic [31:0]       plane_size
);
  logic              fetch_start;
  logic [ADDR_W-1:0] fetch_base;
  logic              fetch_busy;
  logic              fetch_last;
  logic              word_take;
  logic [IDX_W-1:0]  word_idx;
  node_cfg_t         cfg_nx;
  node_cfg_t         act_cfg;
  logic [WORD_W-1:0] ptr_q;

  pf_fetch_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fetch_start),
    .start_base (fetch_base),
    .req_valid  (mem_req_valid),
    .req_ready  (mem_req_ready),
    .req_addr   (mem_req_addr),
    .rsp_valid  (mem_rsp_valid),
    .word_take  (word_take),
    .word_idx   (word_idx),
    .word_last  (fetch_last),
    .busy       (fetch_busy)
  );

  pf_node_stage #(.MAX_W(MAX_W), .MAX_H(MAX_H)) i_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_take (word_take),
    .word_idx  (word_idx),
    .word_data (mem_rsp_data),
    .cfg_nx    (cfg_nx)
  );

  pf_plane_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) i_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .field_sync    (field_sync),
    .fetch_busy    (fetch_busy),
    .fetch_last    (fetch_last),
    .cfg_nx        (cfg_nx),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .pix_underflow (pix_underflow),
    .start         (fetch_start),
    .start_base    (fetch_base),
    .act_cfg       (act_cfg),
    .plane_visible (plane_visible),
    .ptr           (ptr_q),
    .reg_rdata     (reg_rdata)
  );

  assign plane_ctl      = act_cfg.ctl;
  assign plane_origin   = act_cfg.org;
  assign plane_stop     = act_cfg.stop;
  assign plane_pix_addr = act_cfg.pix;
  assign plane_pitch    = act_cfg.pitch;
  assign plane_size     = act_cfg.size;
endmodule

// File: rtl/pf_checker.sv
module pf_checker
  import plane_fetch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8,
  parameter int MAX_W  = 3840,
  parameter int MAX_H  = 2160
) (
  input logic              clk,
  input logic              rst_n,
  input logic              field_sync,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              plane_visible,
  input logic [31:0]       plane_size,
  input logic              fetch_busy,
  input logic              fetch_last,
  input logic [31:0]       ptr
);
  localparam int HALF = 16;
  localparam logic [HALF-1:0] LIM_W = HALF'(MAX_W);
  localparam logic [HALF-1:0] LIM_H = HALF'(MAX_H);
  localparam logic [REG_AW-3:0] LINK_SEL = (REG_AW-2)'(W_LINK);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2

  AST_FIRST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> mem_req_addr[ALIGN_BITS-1:0] == '0); // R8

  AST_SIZE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    plane_size[HALF-1:0] <= LIM_W && plane_size[31:HALF] <= LIM_H); // R6

  AST_ZERO_PTR_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    field_sync && !fetch_busy && ptr == '0 |=> !plane_visible && !mem_req_valid); // R7

  AST_SYNC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    field_sync && fetch_busy && !fetch_last |=> fetch_busy); // R9

  AST_HOST_PTR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr[REG_AW-1:2] == LINK_SEL |=> ptr == $past(reg_wdata)); // R10
endmodule

bind plane_node_fetcher pf_checker #(
  .ADDR_W (ADDR_W),
  .REG_AW (REG_AW),
  .MAX_W  (MAX_W),
  .MAX_H  (MAX_H)
) i_pf_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .field_sync    (field_sync),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .reg_wr        (reg_wr),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .plane_visible (plane_visible),
  .plane_size    (plane_size),
  .fetch_busy    (fetch_busy),
  .fetch_last    (fetch_last),
  .ptr           (ptr_q)
);

// File: tb/test_plane_node_fetcher.sv
`timescale 1ns/1ps
module test_plane_node_fetcher;
  localparam int ADDR_W = 32;
  localparam int REG_AW = 8;
  localparam logic [7:0] OFF_CTL = 8'h00, OFF_ORG = 8'h0C, OFF_PIX = 8'h14,
                         OFF_LINK = 8'h24, OFF_KEYLO = 8'h28, OFF_LUT = 8'h3C,
                         OFF_STAT = 8'h68;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic field_sync = 1'b0;
  logic mem_req_valid;
  logic mem_req_ready = 1'b1;
  logic [ADDR_W-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic reg_wr = 1'b0;
  logic [REG_AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic pix_underflow = 1'b0;
  logic plane_visible;
  logic [31:0] plane_ctl, plane_origin, plane_stop, plane_pix_addr, plane_pitch, plane_size;

  always #2 clk = ~clk;

  plane_node_fetcher i_plane_node_fetcher (.*);

  logic [31:0] mem [0:63];
  logic [7:0]  lfsr = 8'hA5;
  logic        stall_en = 1'b0;
  int          rsp_total = 0;
  int          req_total = 0;
  int          vectors = 0;
  int          misses = 0;
  bit          finished = 1'b0;
  logic [31:0] exp_q [$];

  // memory model: one-cycle latency, optional random back-pressure
  always @(posedge clk) begin
    lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_req_ready <= stall_en ? lfsr[0] : 1'b1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[mem_req_addr[7:2]];
    if (mem_rsp_valid) rsp_total <= rsp_total + 1;
  end

  // scoreboard monitor for read addresses
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      req_total++;
      vectors++;
      if (exp_q.size() == 0) begin
        misses++;
        $display("FAIL R2 unexpected read: actual %h expected none", mem_req_addr);
      end else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        if (mem_req_addr !== e) begin
          misses++;
          $display("FAIL R2 read address: actual %h expected %h", mem_req_addr, e);
        end
      end
    end
  end

  task automatic expect_fetch(input logic [31:0] base);
    for (int i = 0; i < 16; i++) exp_q.push_back(base + 32'(i * 4));
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] off, output logic [31:0] val);
    @(negedge clk);
    reg_addr = off;
    #1;
    val = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] off, input logic [31:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = off; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    field_sync = 1'b1;
    @(negedge clk);
    field_sync = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 500; i++) begin
      rd(OFF_STAT, s);
      if (!s[2]) break;
    end
  endtask

  task automatic load_node(input int base, input logic [31:0] ctl, org, stop, pix,
                           pitch, size, link, prop);
    int k;
    k = base / 4;
    for (int i = 0; i < 16; i++) mem[k + i] = 32'hFFFF_0000 | 32'(i);
    mem[k + 0]  = ctl;    mem[k + 1]  = 32'h0080_8080;
    mem[k + 3]  = org;    mem[k + 4]  = stop;
    mem[k + 5]  = pix;    mem[k + 6]  = pitch;
    mem[k + 7]  = size;   mem[k + 9]  = link;
    mem[k + 10] = 32'hA000_0000 | 32'(base);
    mem[k + 11] = 32'hB000_0000 | 32'(base);
    mem[k + 13] = prop;
    mem[k + 15] = 32'hC000_0000 | 32'(base);
  endtask

  localparam logic [31:0] A_CTL = 32'h0000_0005, B_CTL = 32'h8000_0002, C_CTL = 32'h0000_0007;

  initial begin
    logic [31:0] v;
    int base_cnt;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    load_node(32'h40, A_CTL, {16'd20, 16'd30}, {16'd119, 16'd429}, 32'h1000_0000,
              32'd1600, {16'd100, 16'd4000}, 32'h80, 32'h0);
    load_node(32'h80, B_CTL, {16'd1, 16'd2}, {16'd9, 16'd9}, 32'h2000_0000,
              32'd2560, {16'd3000, 16'd640}, 32'h40, 32'h1);
    load_node(32'hC0, C_CTL, {16'd5, 16'd6}, {16'd54, 16'd65}, 32'h3000_0000,
              32'd240, {16'd50, 16'd60}, 32'h40, 32'h0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 visible", 32'(plane_visible), 0);
    check("R1 req_valid", 32'(mem_req_valid), 0);
    rd(OFF_LINK, v); check("R1 pointer", v, 0);
    rd(OFF_STAT, v); check("R1 status", v, 0);

    // R7 zero pointer: no reads
    pulse_sync();
    repeat (3) @(negedge clk);
    check("R7 visible with zero pointer", 32'(plane_visible), 0);

    // R8 misaligned pointer refused, sticky, write-one-to-clear
    wr(OFF_LINK, 32'h48);
    pulse_sync();
    repeat (3) @(negedge clk);
    rd(OFF_STAT, v); check("R8 error bit set", v, 32'h2);
    wr(OFF_STAT, 32'h2);
    rd(OFF_STAT, v); check("R8 error bit cleared", v, 0);

    // R2 R3 R6 R11 first fetch of node A, immediate
    wr(OFF_LINK, 32'h40);
    expect_fetch(32'h40);
    pulse_sync();
    wait_idle();
    check("R3 ctl A", plane_ctl, A_CTL);
    check("R3 origin A", plane_origin, {16'd20, 16'd30});
    check("R3 stop A", plane_stop, {16'd119, 16'd429});
    check("R3 pix A", plane_pix_addr, 32'h1000_0000);
    check("R3 pitch A", plane_pitch, 32'd1600);
    check("R6 width clamp", plane_size, {16'd100, 16'd3840});
    check("R5 visible A", 32'(plane_visible), 1);
    rd(OFF_LINK, v); check("R3 pointer from link", v, 32'h80);
    rd(OFF_KEYLO, v); check("R11 key word readback", v, 32'hA000_0040);
    rd(OFF_LUT, v); check("R11 lut word readback", v, 32'hC000_0040);

    // R4 deferred node B under back-pressure
    stall_en = 1'b1;
    expect_fetch(32'h80);
    pulse_sync();
    wait_idle();
    stall_en = 1'b0;
    check("R4 deferred keeps A", plane_ctl, A_CTL);
    rd(OFF_LINK, v); check("R3 pointer from B link", v, 32'h40);

    // R4 promotion at sync, same edge starts next fetch
    expect_fetch(32'h40);
    pulse_sync();
    check("R4 B active after sync", plane_ctl, B_CTL);
    check("R5 B hidden", 32'(plane_visible), 0);
    check("R6 height clamp", plane_size, {16'd2160, 16'd640});
    wait_idle();
    check("R4 A immediate", plane_ctl, A_CTL);
    check("R5 A visible again", 32'(plane_visible), 1);

    // R9 sync during fetch ignored
    base_cnt = req_total;
    expect_fetch(32'h80);
    pulse_sync();
    pulse_sync();
    wait_idle();
    check("R9 reads per fetch", 32'(req_total - base_cnt), 16);
    rd(OFF_LINK, v); check("R9 pointer", v, 32'h40);

    // R10 host write during fetch wins over link
    expect_fetch(32'h40);
    pulse_sync();
    wr(OFF_LINK, 32'hC0);
    wait_idle();
    rd(OFF_LINK, v); check("R10 host pointer kept", v, 32'hC0);

    // R10 host write in the commit cycle
    expect_fetch(32'hC0);
    base_cnt = rsp_total;
    pulse_sync();
    for (int i = 0; i < 200; i++) begin
      if (rsp_total == base_cnt + 15 && mem_rsp_valid) break;
      @(negedge clk);
    end
    reg_wr = 1'b1; reg_addr = OFF_LINK; reg_wdata = 32'h80;
    @(negedge clk);
    reg_wr = 1'b0;
    check("R3 ctl C", plane_ctl, C_CTL);
    rd(OFF_LINK, v); check("R10 commit-cycle write", v, 32'h80);

    // R11 writes to read-only offsets ignored
    wr(OFF_CTL, 32'hDEAD_BEEF);
    wr(OFF_PIX, 32'h1234_5678);
    rd(OFF_CTL, v); check("R11 ctl unchanged", v, C_CTL);
    check("R11 pix unchanged", plane_pix_addr, 32'h3000_0000);
    rd(OFF_ORG, v); check("R11 origin readback", v, {16'd5, 16'd6});

    // R12 underflow sticky and clear
    @(negedge clk); pix_underflow = 1'b1;
    @(negedge clk); pix_underflow = 1'b0;
    repeat (3) @(negedge clk);
    rd(OFF_STAT, v); check("R12 underflow sticky", v, 32'h1);
    wr(OFF_STAT, 32'h1);
    rd(OFF_STAT, v); check("R12 underflow cleared", v, 0);

    // R7 zero pointer disables an active plane
    wr(OFF_LINK, 32'h0);
    pulse_sync();
    check("R7 plane dark", 32'(plane_visible), 0);
    repeat (4) @(negedge clk);
    check("R2 no reads left pending", 32'(exp_q.size()), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule